// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a synchronous serial PCM stream into six parallel signed samples. A bit clock, a word clock and three data lines arrive already synchronous to the system clock. The block samples all of them in that domain and finds the rising bit-clock edges. It then assembles most-significant-bit-first two's-complement words and presents all six channels together with a one-cycle valid strobe.

A static two-bit code selects the framing: I2S, left-justified, right-justified, or a time-division multiplexed frame that carries all six channels on the first data line. A second static pin picks 16-bit or 24-bit words for the two-channel formats. A third selects 32-bit or 64-bit TDM slots. Outputs change only when the strobe fires, so a downstream filter can take a complete frame on that cycle.

Top module: `audio_serial_rx`

## Requirements
- R1: Data bits are taken on rising bit-clock edges, MSB first, two's complement. Channel k (0..5) appears on smp_out bits [24k+23:24k].
- R2: fmt_sel selects the framing: 00 is I2S, 01 is TDM, 10 is right-justified and 11 is left-justified.
- R3: In I2S a low word clock marks the left sample. The MSB is the bit on the second rising bit-clock edge after the word clock changes.
- R4: In left-justified mode a high word clock marks the left sample. The MSB is the bit on the first rising bit-clock edge after the word clock changes, and bits after the word are ignored.
- R5: In right-justified mode a high word clock marks the left sample, and the LSB is the last bit of each half frame. This holds for half frames of 16, 24 and 32 bit clocks.
- R6: With word_16b = 1 in the two-channel modes, a 16-bit word is placed in the upper 16 bits and the lower 8 bits are zero. In I2S and left-justified modes, bits after the 16th data bit are ignored.
- R7: Data line l (0..2) feeds channel 2l with its left sample and channel 2l+1 with its right sample.
- R8: In TDM a rising word clock starts the frame, and channel s uses slot s on line 0. A slot is 32 bit clocks (tdm_slot64 = 0) or 64 (tdm_slot64 = 1). Its first 24 bits are the sample MSB first, and the remaining bits and lines 1 and 2 are ignored.
- R9: A 128-bit TDM frame of 32-bit slots delivers channels 0 and 1 correctly.
- R10: smp_valid is a one-cycle pulse, issued once per frame after the last channel is captured: at the end of the right half, or at the next TDM frame start. It is not issued for a frame whose start was not seen after reset. smp_out only changes together with the pulse.
- R11: During reset smp_out is all zero and smp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial clocks are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing code (see R2) |
| word_16b | input | 1 | 1 selects 16-bit words in the two-channel modes |
| tdm_slot64 | input | 1 | 1 selects 64-bit TDM slots, 0 selects 32-bit slots |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Word clock |
| sdata | input | 3 | Serial data lines; bit l is line l |
| smp_out | output | 144 | Six 24-bit samples, channel k at bits [24k+23:24k] |
| smp_valid | output | 1 | One-cycle strobe marking a new complete frame on smp_out |

## Verification
The two-channel formats are driven with junk ones in every bit position outside the word. A capture window placed one bit early or late therefore corrupts the result, which separates I2S from left-justified alignment. Right-justified words are sent in 16-, 24- and 32-bit half frames, so the result shows whether the LSB is anchored to the half-frame end. A 16-bit left-justified run adds junk after the word, which exposes the zero padding. TDM frames of 128, 256 and 512 bit clocks use padded slots and junk on the unused lines. These check the slot decoding and the frame-start edge, and the number of strobes per test shows the pulse is issued once per frame and suppressed for the first partial frame.

// File: rtl/asr_pkg.sv
package asr_pkg;

  localparam int SAMPLE_W = 24;
  localparam int SHORT_W  = 16;
  localparam int PAD_W    = SAMPLE_W - SHORT_W;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_TDM = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_LJ  = 2'b11
  } fmt_e;

  // Aligns a shifted word to the output width; short words get zero LSBs.
  function automatic logic [SAMPLE_W-1:0] align_word(input logic [SAMPLE_W-1:0] sr,
                                                     input logic w16);
    if (w16) return {sr[SHORT_W-1:0], {PAD_W{1'b0}}};
    return sr;
  endfunction

  // True when the bit at index idx of a half frame belongs to the word.
  function automatic logic in_window(input fmt_e fmt, input logic w16, input int idx);
    int n;
    n = w16 ? SHORT_W : SAMPLE_W;
    case (fmt)
      FMT_LJ:  return idx < n;
      FMT_I2S: return (idx >= 1) && (idx <= n);
      FMT_RJ:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Slot number of a TDM frame position; out-of-range positions map to 15.
  function automatic logic [3:0] tdm_slot(input int pos, input logic s64);
    if (s64) return 4'(pos / 64);
    if (pos >= 256) return 4'd15;
    return 4'(pos / 32);
  endfunction

  // Bit position inside the current TDM slot.
  function automatic logic [5:0] tdm_bit(input int pos, input logic s64);
    if (s64) return 6'(pos % 64);
    return 6'(pos % 32);
  endfunction

endpackage

// File: rtl/asr_edge_sync.sv
module asr_edge_sync #(
  parameter int LINES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             lrclk,
  input  logic [LINES-1:0] sdata,
  output logic             rise,
  output logic             lr_prev,
  output logic             lr_edge,
  output logic             lr_up,
  output logic [LINES-1:0] din
);
  logic             b_q, b_qq, l_q, lr_last, primed;
  logic [LINES-1:0] d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_q     <= 1'b0;
      b_qq    <= 1'b0;
      l_q     <= 1'b0;
      d_q     <= '0;
      lr_last <= 1'b0;
      primed  <= 1'b0;
    end else begin
      b_q  <= bclk;
      b_qq <= b_q;
      l_q  <= lrclk;
      d_q  <= sdata;
      if (rise) begin
        lr_last <= l_q;
        primed  <= 1'b1;
      end
    end
  end

  assign rise    = b_q & ~b_qq;
  assign din     = d_q;
  assign lr_prev = lr_last;
  assign lr_edge = rise & primed & (l_q != lr_last);
  assign lr_up   = lr_edge & l_q;

endmodule

// File: rtl/asr_bit_timer.sv
module asr_bit_timer
  import asr_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int CHANS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  logic             w16,
  input  logic             slot64,
  input  logic             rise,
  input  logic             lr_edge,
  input  logic             lr_up,
  output logic [CNT_W-1:0] bit_idx,
  output logic             shift_en,
  output logic             half_end,
  output logic             frame_start,
  output logic             slot_done,
  output logic [3:0]       slot_num
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, cur;
  logic             is_tdm, restart;
  logic [5:0]       bpos;

  assign is_tdm   = (fmt == FMT_TDM);
  assign restart  = is_tdm ? lr_up : lr_edge;
  assign cur      = restart ? '0 : cnt;
  assign slot_num = tdm_slot(int'(cur), slot64);
  assign bpos     = tdm_bit(int'(cur), slot64);

  always_comb begin
    if (is_tdm)
      shift_en = rise && (bpos < 6'(SAMPLE_W)) && (slot_num < 4'(CHANS));
    else
      shift_en = rise && in_window(fmt, w16, int'(cur));
  end

  assign slot_done   = rise && is_tdm && (slot_num < 4'(CHANS)) && (bpos == 6'(SAMPLE_W - 1));
  assign half_end    = lr_edge && !is_tdm;
  assign frame_start = lr_up && is_tdm;
  assign bit_idx     = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= CNT_MAX;
    else if (rise) cnt <= (cur == CNT_MAX) ? CNT_MAX : cur + 1'b1;
  end

endmodule

// File: rtl/asr_lane.sv
module asr_lane #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] sr
);
  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (shift) sr <= {sr[W-2:0], din};
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asr_pkg::*;
#(
  parameter int LINES = 3,
  parameter int CNT_W = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      fmt_sel,
  input  logic                            word_16b,
  input  logic                            tdm_slot64,
  input  logic                            bclk,
  input  logic                            lrclk,
  input  logic [LINES-1:0]                sdata,
  output logic [2*LINES*SAMPLE_W-1:0]     smp_out,
  output logic                            smp_valid
);
  localparam int CHANS = 2 * LINES;

  fmt_e                          fmt;
  logic                          rise_w, lr_prev_w, lr_edge_w, lr_up_w;
  logic [LINES-1:0]              din_w;
  logic [CNT_W-1:0]              bit_idx_w;
  logic                          shift_w, half_end_w, frame_start_w, slot_done_w;
  logic [3:0]                    slot_w;
  logic [LINES-1:0][SAMPLE_W-1:0] sr_w;
  logic [SAMPLE_W-1:0]           tdm_word_w;
  logic                          ended_left_w;
  logic [CHANS-1:0][SAMPLE_W-1:0] stg_q, out_q;
  logic                          started_q, left_seen_q, tdm_seen_q, pend_q, valid_q;

  assign fmt = fmt_e'(fmt_sel);

  asr_edge_sync #(.LINES(LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk    (bclk),
    .lrclk   (lrclk),
    .sdata   (sdata),
    .rise    (rise_w),
    .lr_prev (lr_prev_w),
    .lr_edge (lr_edge_w),
    .lr_up   (lr_up_w),
    .din     (din_w)
  );

  asr_bit_timer #(.CNT_W(CNT_W), .CHANS(CHANS)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt         (fmt),
    .w16         (word_16b),
    .slot64      (tdm_slot64),
    .rise        (rise_w),
    .lr_edge     (lr_edge_w),
    .lr_up       (lr_up_w),
    .bit_idx     (bit_idx_w),
    .shift_en    (shift_w),
    .half_end    (half_end_w),
    .frame_start (frame_start_w),
    .slot_done   (slot_done_w),
    .slot_num    (slot_w)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_lane
    asr_lane #(.W(SAMPLE_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (shift_w),
      .din   (din_w[l]),
      .sr    (sr_w[l])
    );
  end

  // Word completed by the current TDM bit on line 0.
  assign tdm_word_w = {sr_w[0][SAMPLE_W-2:0], din_w[0]};

  // The half that just ended carried the word clock level seen before the edge.
  assign ended_left_w = (fmt == FMT_I2S) ? ~lr_prev_w : lr_prev_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_q       <= '0;
      started_q   <= 1'b0;
      left_seen_q <= 1'b0;
      tdm_seen_q  <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      for (int k = 0; k < CHANS; k++) begin
        if (half_end_w && (ended_left_w == ((k % 2) == 0)))
          stg_q[k] <= align_word(sr_w[k / 2], word_16b);
        else if (slot_done_w && (slot_w == 4'(k)))
          stg_q[k] <= tdm_word_w;
      end
      if (half_end_w) started_q <= 1'b1;
      if (half_end_w && ended_left_w && started_q) left_seen_q <= 1'b1;
      if (frame_start_w) tdm_seen_q <= 1'b1;
      pend_q <= (half_end_w && !ended_left_w && left_seen_q) ||
                (frame_start_w && tdm_seen_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= pend_q;
      if (pend_q) out_q <= stg_q;
    end
  end

  assign smp_out   = out_q;
  assign smp_valid = valid_q;

endmodule

// File: rtl/asr_checker.sv
module asr_checker
  import asr_pkg::*;
#(
  parameter int CHANS = 6,
  parameter int CNT_W = 9
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                fmt_sel,
  input logic                      word_16b,
  input logic [CHANS*SAMPLE_W-1:0] smp_out,
  input logic                      smp_valid,
  input logic                      bclk_rise,
  input logic                      lr_edge,
  input logic                      lr_up,
  input logic [CNT_W-1:0]          bit_idx,
  input logic                      frame_pend
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic pad_zero;
  always_comb begin
    pad_zero = 1'b1;
    for (int k = 0; k < CHANS; k++)
      if (smp_out[k*SAMPLE_W +: PAD_W] != '0) pad_zero = 1'b0;
  end

  assert_rise_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |=> !bclk_rise);

  assert_half_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_rise && lr_edge && fmt_sel != 2'b01) |=> (bit_idx == ONE));

  assert_short_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && word_16b && fmt_sel != 2'b01) |-> pad_zero);

  assert_frame_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_rise && lr_up && fmt_sel == 2'b01) |=> (bit_idx == ONE));

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  assert_pend_to_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pend |=> smp_valid);

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_out));

endmodule

bind audio_serial_rx asr_checker #(.CHANS(CHANS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fmt_sel    (fmt_sel),
  .word_16b   (word_16b),
  .smp_out    (smp_out),
  .smp_valid  (smp_valid),
  .bclk_rise  (rise_w),
  .lr_edge    (lr_edge_w),
  .lr_up      (lr_up_w),
  .bit_idx    (bit_idx_w),
  .frame_pend (pend_q)
);

// File: tb/sim_audio_serial_rx.sv
module sim_audio_serial_rx;
  localparam int CLK_P = 10;
  localparam int HB    = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   fmt_sel = 2'b11;
  logic         word_16b = 1'b0;
  logic         tdm_slot64 = 1'b0;
  logic         bclk = 1'b0;
  logic         lrclk = 1'b0;
  logic [2:0]   sdata = 3'b000;
  logic [143:0] smp_out;
  logic         smp_valid;

  int n_chk = 0;
  int n_fail = 0;
  int vcount = 0;
  logic [143:0] cap = '0;
  logic [23:0]  vals [0:5];

  audio_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .word_16b(word_16b),
    .tdm_slot64(tdm_slot64), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .smp_out(smp_out), .smp_valid(smp_valid)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      vcount <= vcount + 1;
      cap    <= smp_out;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mkval(input int seed, input int k);
    return 24'((seed * 32'h0003B1D5) ^ (k * 32'h0010F0F1) ^ 32'h00800001);
  endfunction

  // Bit driven at index i of a half frame of length hl (junk 1 outside the word).
  function automatic logic bit2(input logic [1:0] f, input bit w16, input int hl,
                                input int i, input logic [23:0] v);
    int n, j;
    n = w16 ? 16 : 24;
    case (f)
      2'b00:   j = i - 1;
      2'b10:   j = i - (hl - n);
      default: j = i;
    endcase
    if (j >= 0 && j < n) return v[23 - j];
    return 1'b1;
  endfunction

  task automatic send_bit(input logic lr, input logic [2:0] d);
    lrclk = lr;
    sdata = d;
    bclk  = 1'b0;
    repeat (HB) @(negedge clk);
    bclk = 1'b1;
    repeat (HB) @(negedge clk);
  endtask

  task automatic apply_reset(input logic [1:0] f, input bit w16, input bit s64, input logic idle_lr);
    @(negedge clk);
    rst_n = 1'b0;
    fmt_sel = f;
    word_16b = w16;
    tdm_slot64 = s64;
    bclk = 1'b0;
    lrclk = idle_lr;
    sdata = 3'b000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(smp_out == '0, "R11 reset samples", smp_out[31:0], 32'h0);
    chk(smp_valid == 1'b0, "R11 reset strobe", {31'b0, smp_valid}, 32'h0);
  endtask

  task automatic run_2ch(input logic [1:0] f, input bit w16, input int hl,
                         input int seed, input string req);
    logic lft, rgt;
    int base;
    logic [23:0] exp;
    lft = (f == 2'b00) ? 1'b0 : 1'b1;
    rgt = ~lft;
    for (int k = 0; k < 6; k++) vals[k] = mkval(seed, k);
    apply_reset(f, w16, 1'b0, rgt);
    base = vcount;
    repeat (2) send_bit(rgt, 3'b000);
    for (int fr = 0; fr < 3; fr++)
      for (int h = 0; h < 2; h++)
        for (int i = 0; i < hl; i++) begin
          logic [2:0] d;
          d = '0;
          for (int l = 0; l < 3; l++) d[l] = bit2(f, w16, hl, i, vals[2*l + h]);
          send_bit((h == 0) ? lft : rgt, d);
        end
    repeat (4) send_bit(lft, 3'b111);
    repeat (6) @(negedge clk);
    chk(vcount - base == 3, {req, " R10 strobes per run"}, 32'(vcount - base), 32'd3);
    for (int k = 0; k < 6; k++) begin
      exp = w16 ? {vals[k][23:8], 8'h00} : vals[k];
      chk(cap[k*24 +: 24] == exp, $sformatf("%s R1 R7 ch%0d", req, k),
          {8'h0, cap[k*24 +: 24]}, {8'h0, exp});
    end
  endtask

  task automatic run_tdm(input bit s64, input int flen, input int nchk,
                         input int seed, input string req);
    int base, sl, s, b;
    logic bt;
    for (int k = 0; k < 6; k++) vals[k] = mkval(seed, k);
    apply_reset(2'b01, 1'b0, s64, 1'b0);
    base = vcount;
    sl = s64 ? 64 : 32;
    repeat (2) send_bit(1'b0, 3'b000);
    for (int fr = 0; fr < 3; fr++)
      for (int i = 0; i < flen; i++) begin
        s = i / sl;
        b = i % sl;
        bt = (s < 6 && b < 24) ? vals[s][23 - b] : 1'b1;
        send_bit(i < flen / 2, {2'b11, bt});
      end
    repeat (4) send_bit(1'b1, 3'b111);
    repeat (6) @(negedge clk);
    chk(vcount - base == 3, {req, " R10 strobes per run"}, 32'(vcount - base), 32'd3);
    for (int k = 0; k < nchk; k++)
      chk(cap[k*24 +: 24] == vals[k], $sformatf("%s R8 slot%0d", req, k),
          {8'h0, cap[k*24 +: 24]}, {8'h0, vals[k]});
  endtask

  initial begin
    repeat (CLK_P * 20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    test_reset();
    run_2ch(2'b11, 1'b0, 32, 11, "R4 R2 left-justified 24b 64fs");
    run_2ch(2'b00, 1'b0, 32, 12, "R3 I2S 24b 64fs");
    run_2ch(2'b10, 1'b1, 16, 13, "R5 R6 right-justified 16b 32fs");
    run_2ch(2'b10, 1'b0, 24, 14, "R5 right-justified 24b 48fs");
    run_2ch(2'b10, 1'b1, 32, 15, "R5 right-justified 16b 64fs");
    run_2ch(2'b11, 1'b1, 32, 16, "R6 left-justified 16b 64fs");
    run_2ch(2'b00, 1'b1, 24, 17, "R6 R3 I2S 16b 48fs");
    run_tdm(1'b0, 256, 6, 18, "R8 TDM 256fs");
    run_tdm(1'b1, 512, 6, 19, "R8 TDM 512fs");
    run_tdm(1'b0, 128, 2, 20, "R9 TDM 128fs");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule